// File: doc/BRIEF.md
# Audio Transmit Sample FIFO

This block buffers outgoing audio samples between a register bus and the codec side of a serial audio link. Each bus write to the data port carries one sample or, in compact mode, two 16-bit samples. Every sample is left-aligned into a 20-bit slot value according to the configured sample width, and the result is stored in a circular buffer whose depth is a parameter.

Samples leave in stereo pairs. The left sample is the older entry and the right sample is the next one. A pair is offered on a valid/ready output. Draining starts only when transmission is enabled, at least one of the two audio slots is selected, and the buffer is at least half full. Once draining has started, it continues with one pair per accepted cycle. It stops when the sink refuses a pair or when fewer than two entries remain.

The block keeps four sticky status bits: empty, half-empty, full and underrun. From these it derives three interrupt flags and one masked interrupt line.

Top module: `audio_tx_fifo`

## Requirements
- R1: The configuration port holds a write. Bit 0 is enable. Bits [2:1] are the width code: 0 means 16 bits, 1 means 18 bits, 2 means 20 bits, 3 means 12 bits. Bit 3 is compact. Bit 4 selects slot 3 and bit 5 selects slot 4. A new configuration takes effect on the cycle after it is written. In non-compact mode, a data word is shifted left by 8, 4, 2 or 0 for 12, 16, 18 or 20 bits, and only the low 20 bits are kept.
- R2: In compact mode, one data word gives two entries. Bits [15:0] are stored first and bits [31:16] second. Each half is shifted left by 8 for the 12-bit width and by 4 otherwise, then cut to 20 bits.
- R3: A configuration write that requests compact mode with the 18-bit or 20-bit width is stored as non-compact.
- R4: A non-compact write is taken only while the level is below DEPTH. A compact write is taken only while the level plus 2 is below DEPTH. Any other data write is dropped and leaves the contents unchanged.
- R5: After an accepted write, a nonzero level clears empty and underrun. A level of at least DEPTH/2 clears half-empty. A level of DEPTH sets full.
- R6: pair_valid is high only when all of the following hold: enable is set, slot 3 or slot 4 is selected, at least two entries are held, and either a drain is in progress or the level is at least DEPTH/2.
- R7: pair_left is the oldest entry and pair_right is the next one. A pair accepted with pair_ready keeps the drain going. A pair refused while valid ends the drain, and a new drain needs half depth again.
- R8: After a pair leaves, full is cleared. A level of at most DEPTH/2 sets half-empty. A level of zero sets both empty and underrun. These rules are applied after the write rules of R5.
- R9: irq_flags[0] follows underrun. irq_flags[1] follows half-empty. irq_flags[2] is empty while no pair is offered. irq is high when any flag is set together with the matching irq_en bit.
- R10: Reset leaves empty and half-empty set and all other state clear. A pulse on urun_clr clears underrun, unless the same cycle's R5 or R8 rules set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration value (fields per R1) |
| dat_wr | input | 1 | Sample data write strobe |
| dat_wdata | input | 32 | Sample data word |
| urun_clr | input | 1 | Clears the underrun status |
| irq_en | input | 3 | Per-flag interrupt enables |
| pair_valid | output | 1 | A stereo pair is offered |
| pair_ready | input | 1 | Sink accepts the offered pair |
| pair_left | output | 20 | Left (older) slot value |
| pair_right | output | 20 | Right (newer) slot value |
| stat_empty | output | 1 | Empty status |
| stat_half | output | 1 | Half-empty status |
| stat_full | output | 1 | Full status |
| stat_urun | output | 1 | Underrun status |
| irq_flags | output | 3 | Unmasked interrupt flags |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong read pointer or a wrong memory write shows on pair_left or pair_right in the same cycle that the corrupted pair is offered. A drift in the level counter shows in one of three ways: pair_valid rises at the wrong time, the status bits move early or late, or an overrun write that should be dropped is taken and later appears in the output stream. A burst flag that is stale is visible on the first cycle after a refusal, because pair_valid then stays high below half depth. The bench replays every cycle through a queue-based model and compares every output on every cycle, so each of these faults is reported in the first cycle it reaches a port.

// File: rtl/atx_pkg.sv
package atx_pkg;
    localparam int SLOT_W = 20;

    typedef enum logic [1:0] {
        SZ_16 = 2'd0,
        SZ_18 = 2'd1,
        SZ_20 = 2'd2,
        SZ_12 = 2'd3
    } width_sel_e;

    // field order gives bit 0 = enable ... bit 5 = slot 4
    typedef struct packed {
        logic       slot4;
        logic       slot3;
        logic       compact;
        width_sel_e width;
        logic       enable;
    } tx_cfg_t;

    typedef struct packed {
        logic urun;
        logic full;
        logic half;
        logic empty;
    } tx_stat_t;
endpackage

// File: rtl/atx_pad.sv
module atx_pad
    import atx_pkg::*;
(
    input  logic [31:0]       word,
    input  width_sel_e        width,
    input  logic              compact,
    output logic [SLOT_W-1:0] first,
    output logic [SLOT_W-1:0] second
);
    logic [4:0] nc_sh;
    logic [4:0] c_sh;

    always_comb begin
        case (width)
            SZ_12:   nc_sh = 5'd8;
            SZ_16:   nc_sh = 5'd4;
            SZ_18:   nc_sh = 5'd2;
            default: nc_sh = 5'd0;
        endcase
        c_sh = (width == SZ_12) ? 5'd8 : 5'd4;
        if (compact) begin
            first  = SLOT_W'({16'h0, word[15:0]} << c_sh);
            second = SLOT_W'({16'h0, word[31:16]} << c_sh);
        end else begin
            first  = SLOT_W'(word << nc_sh);
            second = '0;
        end
    end
endmodule

// File: rtl/atx_store.sv
module atx_store
    import atx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pair_mode,
    input  logic [SLOT_W-1:0] d0,
    input  logic [SLOT_W-1:0] d1,
    input  logic              pop,
    output logic              accept,
    output logic [LW-1:0]     level,
    output logic [LW-1:0]     lvl_next,
    output logic [SLOT_W-1:0] rd_left,
    output logic [SLOT_W-1:0] rd_right
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] lvl;
    } ptr_t;

    ptr_t              s_d, s_q;
    logic [SLOT_W-1:0] mem_d [DEPTH];
    logic [SLOT_W-1:0] mem_q [DEPTH];
    logic [1:0]        n_in, n_out;

    always_comb begin
        s_d    = s_q;
        mem_d  = mem_q;
        accept = push && (pair_mode ? (int'(s_q.lvl) + 2 < DEPTH)
                                    : (int'(s_q.lvl) < DEPTH));
        n_in   = accept ? (pair_mode ? 2'd2 : 2'd1) : 2'd0;
        n_out  = pop ? 2'd2 : 2'd0;
        if (pop) s_d.rp = s_q.rp + AW'(2);
        if (accept) begin
            mem_d[s_q.wp] = d0;
            if (pair_mode) mem_d[s_q.wp + AW'(1)] = d1;
            s_d.wp = s_q.wp + AW'(n_in);
        end
        s_d.lvl  = s_q.lvl + LW'(n_in) - LW'(n_out);
        lvl_next = s_d.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) mem_q <= mem_d;

    assign level    = s_q.lvl;
    assign rd_left  = mem_q[s_q.rp];
    assign rd_right = mem_q[s_q.rp + AW'(1)];

    p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= DEPTH);
    p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !accept && !pop) |=> $stable(level));
    p_pop_avail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> int'(level) >= 2);
endmodule

// File: rtl/atx_ctl.sv
module atx_ctl
    import atx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LW = $clog2(DEPTH) + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [5:0]    cfg_wdata,
    input  logic          urun_clr,
    input  logic [2:0]    irq_en,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] lvl_next,
    input  logic          accept,
    input  logic          pair_ready,
    output tx_cfg_t       cfg,
    output logic          pair_valid,
    output logic          pop,
    output tx_stat_t      stat,
    output logic [2:0]    flags,
    output logic          irq
);
    typedef struct packed {
        tx_cfg_t  cfg;
        tx_stat_t stat;
        logic     burst;
    } ctl_t;

    ctl_t s_d, s_q;

    always_comb begin
        pair_valid = s_q.cfg.enable && (s_q.cfg.slot3 || s_q.cfg.slot4)
                     && int'(level) >= 2 && (s_q.burst || int'(level) >= HALF);
        pop = pair_valid && pair_ready;

        s_d       = s_q;
        s_d.burst = pop;
        if (cfg_wr) begin
            s_d.cfg = tx_cfg_t'(cfg_wdata);
            if (s_d.cfg.width == SZ_18 || s_d.cfg.width == SZ_20) s_d.cfg.compact = 1'b0;
        end
        if (urun_clr) s_d.stat.urun = 1'b0;
        if (accept) begin
            if (int'(lvl_next) > 0) begin
                s_d.stat.empty = 1'b0;
                s_d.stat.urun  = 1'b0;
            end
            if (int'(lvl_next) >= HALF)  s_d.stat.half = 1'b0;
            if (int'(lvl_next) >= DEPTH) s_d.stat.full = 1'b1;
        end
        if (pop) begin
            s_d.stat.full = 1'b0;
            if (int'(lvl_next) <= HALF) s_d.stat.half = 1'b1;
            if (int'(lvl_next) == 0) begin
                s_d.stat.empty = 1'b1;
                s_d.stat.urun  = 1'b1;
            end
        end

        flags = {s_q.stat.empty && !pair_valid, s_q.stat.half, s_q.stat.urun};
        irq   = |(flags & irq_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.stat.empty <= 1'b1;
            s_q.stat.half  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg  = s_q.cfg;
    assign stat = s_q.stat;

    p_urun_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat.urun |-> stat.empty);
    p_empty_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stat.empty == (int'(level) == 0));
    p_full_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stat.full == (int'(level) == DEPTH));
    p_refuse_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && !pair_ready && !accept && !cfg_wr && int'(level) < HALF) |=> !pair_valid);
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
    import atx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_wdata,
    input  logic        dat_wr,
    input  logic [31:0] dat_wdata,
    input  logic        urun_clr,
    input  logic [2:0]  irq_en,
    output logic        pair_valid,
    input  logic        pair_ready,
    output logic [19:0] pair_left,
    output logic [19:0] pair_right,
    output logic        stat_empty,
    output logic        stat_half,
    output logic        stat_full,
    output logic        stat_urun,
    output logic [2:0]  irq_flags,
    output logic        irq
);
    localparam int LW = $clog2(DEPTH) + 1;

    tx_cfg_t           cfg;
    tx_stat_t          stat;
    logic [SLOT_W-1:0] d0, d1;
    logic              accept, pop;
    logic [LW-1:0]     level, lvl_next;

    atx_pad u_pad (
        .word    (dat_wdata),
        .width   (cfg.width),
        .compact (cfg.compact),
        .first   (d0),
        .second  (d1)
    );

    atx_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (dat_wr),
        .pair_mode (cfg.compact),
        .d0        (d0),
        .d1        (d1),
        .pop       (pop),
        .accept    (accept),
        .level     (level),
        .lvl_next  (lvl_next),
        .rd_left   (pair_left),
        .rd_right  (pair_right)
    );

    atx_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .urun_clr   (urun_clr),
        .irq_en     (irq_en),
        .level      (level),
        .lvl_next   (lvl_next),
        .accept     (accept),
        .pair_ready (pair_ready),
        .cfg        (cfg),
        .pair_valid (pair_valid),
        .pop        (pop),
        .stat       (stat),
        .flags      (irq_flags),
        .irq        (irq)
    );

    assign stat_empty = stat.empty;
    assign stat_half  = stat.half;
    assign stat_full  = stat.full;
    assign stat_urun  = stat.urun;
endmodule

// File: tb/audio_tx_fifo_tb.sv
module audio_tx_fifo_tb;
    localparam int DEPTH = 8;
    localparam int HALF  = DEPTH / 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr, dat_wr, urun_clr, pair_ready;
    logic [5:0]  cfg_wdata;
    logic [31:0] dat_wdata;
    logic [2:0]  irq_en;
    logic        pair_valid, stat_empty, stat_half, stat_full, stat_urun, irq;
    logic [19:0] pair_left, pair_right;
    logic [2:0]  irq_flags;

    always #4 clk = ~clk;

    audio_tx_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .urun_clr(urun_clr), .irq_en(irq_en),
        .pair_valid(pair_valid), .pair_ready(pair_ready), .pair_left(pair_left),
        .pair_right(pair_right), .stat_empty(stat_empty), .stat_half(stat_half),
        .stat_full(stat_full), .stat_urun(stat_urun), .irq_flags(irq_flags), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // behavioural model state
    int unsigned q[$];
    bit m_en, m_cmp, m_s3, m_s4;
    int m_w;
    bit e, h, f, u, burst;

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit model_valid();
        return m_en && (m_s3 || m_s4) && q.size() >= 2 && (burst || q.size() >= HALF);
    endfunction

    task automatic compare_all(input logic [2:0] ie);
        bit mv;
        logic [2:0] fl;
        mv = model_valid();
        fl = {e && !mv, h, u};
        cmp("R6 pair_valid", pair_valid, mv);
        if (mv) begin
            cmp("R7 pair_left", pair_left, q[0]);
            cmp("R7 pair_right", pair_right, q[1]);
        end
        cmp("R5 R8 status empty/half/full/urun", {stat_empty, stat_half, stat_full, stat_urun}, {e, h, f, u});
        cmp("R9 irq_flags", irq_flags, fl);
        cmp("R9 irq", irq, |(fl & ie));
    endtask

    task automatic advance(input bit cw, input logic [5:0] cd, input bit dw,
                           input logic [31:0] dd, input bit uc, input bit rdy);
        bit pop, acc;
        int sz, sh, csh;
        pop = model_valid() && rdy;
        acc = 0;
        sz  = q.size();
        sh  = (m_w == 3) ? 8 : (m_w == 0) ? 4 : (m_w == 1) ? 2 : 0;
        csh = (m_w == 3) ? 8 : 4;
        if (pop) begin
            void'(q.pop_front());
            void'(q.pop_front());
        end
        if (dw) begin
            if (m_cmp) begin
                if (sz + 2 < DEPTH) begin
                    acc = 1;
                    q.push_back(((dd & 32'hFFFF) << csh) & 32'hFFFFF);
                    q.push_back(((dd >> 16) << csh) & 32'hFFFFF);
                end
            end else if (sz < DEPTH) begin
                acc = 1;
                q.push_back((dd << sh) & 32'hFFFFF);
            end
        end
        if (uc) u = 0;
        if (acc) begin
            if (q.size() > 0) begin e = 0; u = 0; end
            if (q.size() >= HALF) h = 0;
            if (q.size() >= DEPTH) f = 1;
        end
        if (pop) begin
            f = 0;
            if (q.size() <= HALF) h = 1;
            if (q.size() == 0) begin e = 1; u = 1; end
        end
        burst = pop;
        if (cw) begin
            m_en  = cd[0];
            m_w   = int'(cd[2:1]);
            m_cmp = cd[3] && (cd[2:1] == 2'd0 || cd[2:1] == 2'd3);
            m_s3  = cd[4];
            m_s4  = cd[5];
        end
    endtask

    task automatic step(input bit cw, input logic [5:0] cd, input bit dw, input logic [31:0] dd,
                        input bit uc, input logic [2:0] ie, input bit rdy);
        @(negedge clk);
        cfg_wr = cw; cfg_wdata = cd; dat_wr = dw; dat_wdata = dd;
        urun_clr = uc; irq_en = ie; pair_ready = rdy;
        #1;
        compare_all(ie);
        advance(cw, cd, dw, dd, uc, rdy);
    endtask

    task automatic idle(input bit rdy);
        step(0, 6'h0, 0, 32'h0, 0, 3'b001, rdy);
    endtask

    task automatic cfgw(input logic [5:0] cd);
        step(1, cd, 0, 32'h0, 0, 3'b001, 0);
    endtask

    task automatic dataw(input logic [31:0] dd);
        step(0, 6'h0, 1, dd, 0, 3'b001, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_wr = 0; cfg_wdata = 0; dat_wr = 0; dat_wdata = 0;
        urun_clr = 0; irq_en = 0; pair_ready = 0;
        q.delete(); m_en = 0; m_cmp = 0; m_s3 = 0; m_s4 = 0; m_w = 0;
        e = 1; h = 1; f = 0; u = 0; burst = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R10 reset state
        idle(0);
        cmp("R10 reset status", {stat_empty, stat_half, stat_full, stat_urun}, 4'b1100);
        cmp("R10 reset flags", irq_flags, 3'b110);

        // R1 12-bit padding, R7 pairing and refusal, R8 drain status
        cfgw(6'h17);
        dataw(32'h123); dataw(32'h456); dataw(32'h789); dataw(32'hABC);
        idle(0);
        cmp("R1 left 12-bit", pair_left, 32'h12300);
        cmp("R1 right 12-bit", pair_right, 32'h45600);
        cmp("R5 half cleared", stat_half, 1'b0);
        idle(1);
        idle(0);
        cmp("R7 drain continues", pair_valid, 1'b1);
        cmp("R7 next left", pair_left, 32'h78900);
        idle(1);
        cmp("R7 refusal ends drain", pair_valid, 1'b0);
        dataw(32'hDEF); dataw(32'h111);
        idle(1); idle(1); idle(0);
        cmp("R8 empty and underrun", {stat_empty, stat_urun}, 2'b11);
        cmp("R9 irq underrun", irq, 1'b1);
        step(0, 6'h0, 0, 32'h0, 1, 3'b001, 0);
        idle(0);
        cmp("R10 underrun clear", stat_urun, 1'b0);
        cmp("R9 irq after clear", irq, 1'b0);

        // R3 compact forced off for 18-bit
        cfgw(6'h0A);
        dataw(32'h3FFFF); dataw(32'h1);
        cfgw(6'h2B);
        dataw(32'h5); dataw(32'h6);
        idle(0);
        cmp("R3 left 18-bit", pair_left, 32'hFFFFC);
        cmp("R3 right 18-bit", pair_right, 32'h00004);
        idle(1); idle(1); idle(0);
        cmp("R3 four single entries", stat_empty, 1'b1);

        // R4 non-compact overrun at 20-bit
        cfgw(6'h04);
        for (int i = 1; i <= 8; i++) dataw(32'h11111 * i);
        idle(0);
        cmp("R5 full set", stat_full, 1'b1);
        dataw(32'hFFFFF);
        cfgw(6'h15);
        idle(0);
        cmp("R4 first pair kept", {pair_left, pair_right}, {20'h11111, 20'h22222});
        idle(1); idle(1); idle(1); idle(1); idle(0);
        cmp("R4 dropped word absent", stat_empty, 1'b1);

        // R2 compact 16-bit, R4 compact overrun
        cfgw(6'h08);
        dataw(32'hBBBBAAAA); dataw(32'hDDDDCCCC); dataw(32'h22221111); dataw(32'h44443333);
        cfgw(6'h19);
        idle(0);
        cmp("R2 compact left", pair_left, 32'hAAAA0);
        cmp("R2 compact right", pair_right, 32'hBBBB0);
        idle(1); idle(1); idle(1); idle(0);
        cmp("R4 compact overrun dropped", stat_empty, 1'b1);

        // R6 no slot selected
        cfgw(6'h01);
        dataw(32'h1); dataw(32'h2); dataw(32'h3); dataw(32'h4);
        idle(1);
        cmp("R6 no slot no drain", pair_valid, 1'b0);

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic [5:0] cd;
            cd = 6'($urandom);
            cd[0] = ($urandom % 4) != 0;
            step(($urandom % 16) == 0, cd, $urandom % 2, $urandom,
                 ($urandom % 8) == 0, 3'($urandom), ($urandom % 3) != 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule